// File: doc/BRIEF.md
# Narrow Pulse Capturing Synchronizer

This block moves a single asynchronous event into a destination clock domain, including events whose pulse is much shorter than one destination clock period. In its default pulse mode a capture flop is clocked by the rising edge of the event line itself and loads a constant one. Two destination-clock flops then carry that level across, and the second one drives the output. As soon as the output goes high it clears, asynchronously, both the capture flop and the first destination stage. Each captured event therefore appears as exactly one output cycle, and the path is ready for the next event about three clocks after capture.

A parameter selects a plain two-flop mode instead. In that mode the event line is sampled directly by the destination clock, which suits level signals that stay high for longer than a clock period.

Top module: `pulse_sync`

## Requirements
- R1: In pulse mode (PULSE_MODE=1), a rising edge on async_in is captured even if async_in returns low before the next rising edge of clk.
- R2: In pulse mode, when async_in rises strictly between two rising clk edges, sync_out goes high at the second rising clk edge after the async_in edge.
- R3: In pulse mode, sync_out stays high for exactly one clk cycle for each captured event.
- R4: In pulse mode, several rising edges of async_in inside the same clk cycle give a single output pulse. An async_in held high across many cycles also gives a single output pulse.
- R5: In pulse mode, the rising edge of sync_out clears the capture stage asynchronously. An event that starts at least four clk cycles after the previous one gives its own output pulse.
- R6: rst (active high, asynchronous) clears every flop and holds sync_out low. An event captured just before or during reset gives no output pulse.
- R7: In plain mode (PULSE_MODE=0), sync_out equals async_in as sampled two rising clk edges earlier. It rises at the second edge after async_in rises and falls at the second edge after async_in falls.
- R8: Outside reset, sync_out changes only at a rising edge of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| async_in | input | 1 | Asynchronous event or level to be carried into the clk domain |
| clk | input | 1 | Destination clock |
| rst | input | 1 | Asynchronous active-high reset |
| sync_out | output | 1 | Synchronized output in the clk domain |

## Verification
The hardest situation to create from the ports is an event that lives entirely between two clock edges: no edge ever samples it high, so only the self-clocked capture flop can record it. The stimulus places pulses of a fraction of a clock period at random phases inside a cycle. It also sends bursts of two pulses within one cycle, and a pulse just before an asynchronous reset. The monitor expects each output cycle at the edge predicted from the cycle in which the pulse started.

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter bit PULSE_MODE = 1'b1
) (
  input  logic async_in,
  input  logic clk,
  input  logic rst,
  output logic sync_out
);

  logic held;
  logic meta_q;
  logic sync_q;

  generate
    if (PULSE_MODE) begin : g_pulse
      logic cap_q;
      logic clr;

      assign clr = rst | sync_q;

      always_ff @(posedge async_in or posedge clr) begin
        if (clr) cap_q <= 1'b0;
        else     cap_q <= 1'b1;
      end

      always_ff @(posedge clk or posedge clr) begin
        if (clr) meta_q <= 1'b0;
        else     meta_q <= cap_q;
      end

      assign held = cap_q;
    end else begin : g_plain
      always_ff @(posedge clk or posedge rst) begin
        if (rst) meta_q <= 1'b0;
        else     meta_q <= async_in;
      end

      assign held = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sync_q <= 1'b0;
    else     sync_q <= meta_q;
  end

  assign sync_out = sync_q;

endmodule

module pulse_sync_chk #(
  parameter bit PULSE_MODE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic held,
  input logic meta_q,
  input logic sync_out
);

  a_r7_stage_follow: assert property (@(posedge clk) disable iff (rst)
    meta_q |=> sync_out);

  a_r6_reset_release: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !sync_out);

  generate
    if (PULSE_MODE) begin : g_pchk
      a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
        sync_out |=> !sync_out);

      a_r5_clear_capture: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> !held && !meta_q);

      a_r2_rise_source: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_out) |-> $past(meta_q));
    end
  endgenerate

endmodule

bind pulse_sync pulse_sync_chk #(.PULSE_MODE(PULSE_MODE)) u_chk (
  .clk(clk), .rst(rst), .held(held), .meta_q(meta_q), .sync_out(sync_out)
);

// File: tb/pulse_sync_bench.sv
`timescale 1ns/1ps
module pulse_sync_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_p = 1'b0;
  logic a_l = 1'b0;
  logic y_p, y_l;

  int n_chk = 0;
  int n_fail = 0;
  int edge_n = 0;
  realtime last_pos = 0;
  int q_p[$];
  int q_l[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_sync #(.PULSE_MODE(1'b1)) u_pulse_sync (
    .async_in(a_p), .clk(clk), .rst(rst), .sync_out(y_p));
  pulse_sync #(.PULSE_MODE(1'b0)) u_pulse_sync_plain (
    .async_in(a_l), .clk(clk), .rst(rst), .sync_out(y_l));

  always @(posedge clk) begin
    edge_n++;
    last_pos = $realtime;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, edge_n, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scoreboard monitor (R1 R2 R3 R4 R5 R7)
  always @(negedge clk) begin
    if (!rst) begin
      if (q_p.size() > 0 && q_p[0] == edge_n) begin
        check(y_p == 1'b1, "R2", int'(y_p), 1);
        void'(q_p.pop_front());
      end else begin
        check(y_p == 1'b0, "R3", int'(y_p), 0);
      end
      if (q_l.size() > 0 && q_l[0] == edge_n) begin
        check(y_l == 1'b1, "R7", int'(y_l), 1);
        void'(q_l.pop_front());
      end else begin
        check(y_l == 1'b0, "R7", int'(y_l), 0);
      end
    end else begin
      check(y_p == 1'b0 && y_l == 1'b0, "R6", int'({y_p, y_l}), 0);
    end
  end

  // R8: output moves only at rising clk edges
  always @(y_p or y_l) begin
    if (!rst && edge_n > 0)
      check($realtime == last_pos && clk == 1'b1, "R8", int'($realtime), int'(last_pos));
  end

  task automatic pulse_once(input int ph_ps, input int w_ps);
    @(posedge clk);
    #(ph_ps / 1000.0);
    a_p = 1'b1;
    q_p.push_back(edge_n + 2);
    #(w_ps / 1000.0);
    a_p = 1'b0;
    repeat (5) @(posedge clk);
  endtask

  initial begin
    #1;
    check(y_p == 1'b0 && y_l == 1'b0, "R6", int'({y_p, y_l}), 0);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 R2 R3 R5: narrow pulses at random phases
    for (int i = 0; i < 40; i++) begin
      int ph;
      int w;
      ph = 200 + int'($urandom_range(3300));
      w = 100 + int'($urandom_range(1200));
      pulse_once(ph, w);
    end

    // R4: two edges in one cycle merge into one event
    @(posedge clk);
    #0.5 a_p = 1'b1;
    q_p.push_back(edge_n + 2);
    #0.3 a_p = 1'b0;
    #0.4 a_p = 1'b1;
    #0.3 a_p = 1'b0;
    repeat (5) @(posedge clk);

    // R4: long level gives one pulse
    @(posedge clk);
    #1.3 a_p = 1'b1;
    q_p.push_back(edge_n + 2);
    repeat (6) @(posedge clk);
    #1 a_p = 1'b0;
    repeat (5) @(posedge clk);

    // R6: event captured then reset before it emerges
    @(posedge clk);
    #1 a_p = 1'b1;
    #0.5 a_p = 1'b0;
    #0.5 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    repeat (5) @(posedge clk);
    #1 check(y_p == 1'b0, "R6", int'(y_p), 0);

    // R7: plain mode, wide levels
    for (int i = 0; i < 8; i++) begin
      int len;
      int st;
      len = 2 + i;
      @(posedge clk);
      #(0.3 + 0.4 * i);
      a_l = 1'b1;
      st = edge_n;
      for (int k = 2; k <= len + 1; k++) q_l.push_back(st + k);
      repeat (len) @(posedge clk);
      #(0.3 + 0.4 * i);
      a_l = 1'b0;
      repeat (4) @(posedge clk);
    end

    repeat (4) @(posedge clk);
    #1;
    check(q_p.size() == 0, "R1", q_p.size(), 0);
    check(q_l.size() == 0, "R7", q_l.size(), 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule